// File: doc/BRIEF.md
# Serial Bus Host Command Frontend

This block sits between a memory-mapped host port and the transaction port of a serial bus engine. Software places one byte transfer at a time by writing a command word that holds a direction flag, the low byte of the target address and, for writes, the data byte. A separate mode register supplies the upper seven address bits and four mode bits. The frontend joins the two address parts into a 15-bit target address and raises a request toward the engine. It then tracks progress through three status flags: busy, ready and read-data-ready.

A read finishes when the engine acknowledges. The returned byte is then latched in the read-data register and read-ready rises. A write finishes when busy drops. If software writes a command while the frontend is not ready, the command is dropped and a sticky overrun flag is raised, which software clears by writing one to it. Repeated accesses to one address are made as separate commands, each issued once ready returns.

Top module: `sbus_host_front`

## Requirements
- R1: After reset, status reads 0x2 (ready=1 at bit 1; busy bit 0, read-ready bit 2 and overrun bit 3 all 0), the mode register reads 0 and no request is raised.
- R2: A write to the command register at offset 0x08 while ready is set is accepted. On the next cycle busy (status bit 0) is 1, ready is 0, and the request is raised with direction = command bit 24 (1 = read), address = {mode bits 10:4, command bits 23:16} and data = command bits 7:0.
- R3: When the engine acknowledges a write, busy clears and ready sets on the next cycle, and read-ready stays 0.
- R4: When the engine acknowledges a read, read-ready (status bit 2) sets on the next cycle. The register at offset 0x10 then returns the engine's byte in bits 7:0, with zeros above.
- R5: A host read of offset 0x10 clears read-ready. The latched byte stays readable.
- R6: An accepted new command clears read-ready.
- R7: A command write while ready is 0 is ignored: the pending request keeps its fields. It sets the sticky overrun flag in status bit 3.
- R8: A write to status at offset 0x14 clears overrun only when written bit 3 is 1. Writing 0 there leaves overrun set.
- R9: The mode register at offset 0x1C stores bits 10:0 and reads them back, with zeros above. Bits 3:0 keep their value across a read-modify-write that changes only the address field (bits 10:4).
- R10: While a request is pending and not yet acknowledged, it stays raised with stable direction, address and data.
- R11: Back-to-back byte transfers to the same address are each accepted as soon as ready returns, and each returns its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 8 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational for the offset) |
| req_valid | output | 1 | Request pending toward the engine |
| req_read | output | 1 | Request direction, 1 = read |
| req_addr | output | 15 | Assembled target address |
| req_wdata | output | 8 | Byte to write |
| eng_ack | input | 1 | Engine completion pulse |
| eng_rdata | input | 8 | Byte returned with a read acknowledge |

## Verification
The bench aims at address assembly across the two registers. A design that swaps or truncates the high part would raise requests with the wrong address, and the engine-side scoreboard catches that. It fires a command while busy: a frontend that accepts it would corrupt the pending request, and one that forgets to flag it would leave bit 3 clear. It checks the clearing rules of read-ready on a data read and on a new command, and also checks that writing zero does not clear overrun. It runs back-to-back reads of one address; a design that left ready low one cycle too long, or reused a stale byte, would fail the per-byte compare.

// File: rtl/sbus_front_pkg.sv
package sbus_front_pkg;

    localparam int HOST_AW   = 8;
    localparam int HOST_DW   = 32;
    localparam int BYTE_W    = 8;
    localparam int HI_W      = 7;
    localparam int MODEBIT_W = 4;
    localparam int TADDR_W   = BYTE_W + HI_W;
    localparam int MODE_W    = MODEBIT_W + HI_W;

    localparam logic [HOST_AW-1:0] OFS_CMD  = 8'h08;
    localparam logic [HOST_AW-1:0] OFS_RD   = 8'h10;
    localparam logic [HOST_AW-1:0] OFS_STAT = 8'h14;
    localparam logic [HOST_AW-1:0] OFS_MODE = 8'h1C;

    localparam int DIR_BIT     = 24;
    localparam int ALO_LSB     = 16;
    localparam int OVR_BIT     = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_RD,
        SEL_STAT,
        SEL_MODE
    } reg_sel_e;

    typedef struct packed {
        logic               rd;
        logic [TADDR_W-1:0] addr;
        logic [BYTE_W-1:0]  data;
    } xfer_req_t;

    typedef struct packed {
        logic overrun;
        logic rd_ready;
        logic ready;
        logic busy;
    } stat_t;

    function automatic reg_sel_e decode_ofs(input logic [HOST_AW-1:0] ofs);
        case (ofs)
            OFS_CMD:  return SEL_CMD;
            OFS_RD:   return SEL_RD;
            OFS_STAT: return SEL_STAT;
            OFS_MODE: return SEL_MODE;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic xfer_req_t build_req(input logic [HOST_DW-1:0] cmd,
                                            input logic [MODE_W-1:0]  mode);
        xfer_req_t r;
        r.rd   = cmd[DIR_BIT];
        r.addr = {mode[MODE_W-1:MODEBIT_W], cmd[ALO_LSB +: BYTE_W]};
        r.data = cmd[BYTE_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/sbus_regdec.sv
module sbus_regdec
    import sbus_front_pkg::*;
(
    input  logic               wr,
    input  logic               rd,
    input  logic [HOST_AW-1:0] addr,
    output reg_sel_e           sel,
    output logic               wr_cmd,
    output logic               wr_stat,
    output logic               wr_mode,
    output logic               rd_data
);
    always_comb begin
        sel     = decode_ofs(addr);
        wr_cmd  = wr && (sel == SEL_CMD);
        wr_stat = wr && (sel == SEL_STAT);
        wr_mode = wr && (sel == SEL_MODE);
        rd_data = rd && (sel == SEL_RD);
    end
endmodule

// File: rtl/sbus_cmd_seq.sv
module sbus_cmd_seq
    import sbus_front_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_cmd,
    input  logic [HOST_DW-1:0] cmd_word,
    input  logic [MODE_W-1:0]  mode,
    input  logic               ack,
    output logic               busy,
    output logic               accept,
    output logic               reject,
    output logic               done,
    output xfer_req_t          req
);
    assign accept = wr_cmd && !busy;
    assign reject = wr_cmd && busy;
    assign done   = busy && ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            req  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            req  <= build_req(cmd_word, mode);
        end else if (done) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/sbus_status_regs.sv
module sbus_status_regs
    import sbus_front_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic               reject,
    input  logic               done,
    input  logic               done_is_read,
    input  logic [BYTE_W-1:0]  eng_byte,
    input  logic               rd_data,
    input  logic               wr_stat,
    input  logic               wr_mode,
    input  logic [HOST_DW-1:0] wdata,
    output logic               rd_ready,
    output logic               overrun,
    output logic [BYTE_W-1:0]  rd_byte,
    output logic [MODE_W-1:0]  mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ready <= 1'b0;
            rd_byte  <= '0;
        end else if (done && done_is_read) begin
            rd_ready <= 1'b1;
            rd_byte  <= eng_byte;
        end else if (accept || rd_data) begin
            rd_ready <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            overrun <= 1'b0;
        else if (reject)
            overrun <= 1'b1;
        else if (wr_stat && wdata[OVR_BIT])
            overrun <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode <= '0;
        else if (wr_mode)
            mode <= wdata[MODE_W-1:0];
    end
endmodule

// File: rtl/sbus_host_front.sv
module sbus_host_front
    import sbus_front_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               req_valid,
    output logic               req_read,
    output logic [TADDR_W-1:0] req_addr,
    output logic [BYTE_W-1:0]  req_wdata,
    input  logic               eng_ack,
    input  logic [BYTE_W-1:0]  eng_rdata
);
    reg_sel_e          sel;
    logic              wr_cmd, wr_stat, wr_mode, rd_data;
    logic              busy, accept, reject, done;
    logic              rd_ready, overrun;
    logic [BYTE_W-1:0] rd_byte;
    logic [MODE_W-1:0] mode;
    xfer_req_t         req;
    stat_t             stat;
    logic [3:0]        stat_vec;

    sbus_regdec u_dec (
        .wr      (host_wr),
        .rd      (host_rd),
        .addr    (host_addr),
        .sel     (sel),
        .wr_cmd  (wr_cmd),
        .wr_stat (wr_stat),
        .wr_mode (wr_mode),
        .rd_data (rd_data)
    );

    sbus_cmd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_cmd   (wr_cmd),
        .cmd_word (host_wdata),
        .mode     (mode),
        .ack      (eng_ack),
        .busy     (busy),
        .accept   (accept),
        .reject   (reject),
        .done     (done),
        .req      (req)
    );

    sbus_status_regs u_stat (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .reject       (reject),
        .done         (done),
        .done_is_read (req.rd),
        .eng_byte     (eng_rdata),
        .rd_data      (rd_data),
        .wr_stat      (wr_stat),
        .wr_mode      (wr_mode),
        .wdata        (host_wdata),
        .rd_ready     (rd_ready),
        .overrun      (overrun),
        .rd_byte      (rd_byte),
        .mode         (mode)
    );

    always_comb begin
        stat.overrun  = overrun;
        stat.rd_ready = rd_ready;
        stat.ready    = !busy;
        stat.busy     = busy;
        stat_vec      = stat;
    end

    always_comb begin
        case (sel)
            SEL_RD:   host_rdata = {{(HOST_DW-BYTE_W){1'b0}}, rd_byte};
            SEL_STAT: host_rdata = {{(HOST_DW-4){1'b0}}, stat_vec};
            SEL_MODE: host_rdata = {{(HOST_DW-MODE_W){1'b0}}, mode};
            default:  host_rdata = '0;
        endcase
    end

    assign req_valid = busy;
    assign req_read  = req.rd;
    assign req_addr  = req.addr;
    assign req_wdata = req.data;
endmodule

// File: rtl/sbus_front_checker.sv
module sbus_front_checker
    import sbus_front_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               host_wr,
    input logic [HOST_AW-1:0] host_addr,
    input logic [HOST_DW-1:0] host_wdata,
    input logic               req_valid,
    input logic               req_read,
    input logic [TADDR_W-1:0] req_addr,
    input logic [BYTE_W-1:0]  req_wdata,
    input logic               eng_ack,
    input logic [3:0]         stat_bits
);
    logic cmd_hit, clr_hit;
    assign cmd_hit = host_wr && (host_addr == OFS_CMD);
    assign clr_hit = host_wr && (host_addr == OFS_STAT) && host_wdata[OVR_BIT];

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_hit && stat_bits[1] |=> req_valid && stat_bits[0] && !stat_bits[1]);

    assert_done_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid && eng_ack |=> !req_valid && stat_bits[1]);

    assert_rdready_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid && eng_ack && req_read |=> stat_bits[2]);

    assert_overrun_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_hit && !stat_bits[1] |=> stat_bits[3]);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        stat_bits[3] && !clr_hit |=> stat_bits[3]);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid && !eng_ack |=> req_valid && $stable(req_addr)
                                  && $stable(req_read) && $stable(req_wdata));
endmodule

bind sbus_host_front sbus_front_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .req_valid  (req_valid),
    .req_read   (req_read),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .eng_ack    (eng_ack),
    .stat_bits  (stat_vec)
);

// File: tb/sbus_host_front_test.sv
module sbus_host_front_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  ENG_LAT    = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        req_valid, req_read;
    logic [14:0] req_addr;
    logic [7:0]  req_wdata;
    logic        eng_ack = 1'b0;
    logic [7:0]  eng_rdata = '0;

    int checks = 0;
    int errors = 0;
    logic [23:0] exp_q[$];

    sbus_host_front uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr),
        .req_wdata(req_wdata), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] eng_byte(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // engine model and scoreboard monitor
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (eng_ack) begin
                eng_ack = 1'b0;
                wait_cnt = 0;
            end else if (req_valid) begin
                wait_cnt++;
                if (wait_cnt == ENG_LAT) begin
                    logic [23:0] got, exp;
                    got = {req_read, req_addr, req_wdata};
                    if (exp_q.size() == 0) exp = 24'hFFFFFF;
                    else exp = exp_q.pop_front();
                    chk(got == exp, "R2 request fields", {8'h0, got}, {8'h0, exp});
                    eng_rdata = eng_byte(req_addr);
                    eng_ack = 1'b1;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    logic [6:0] cur_hi = '0;

    task automatic send_cmd(input bit rd, input logic [7:0] lo, input logic [7:0] d);
        exp_q.push_back({rd, cur_hi, lo, rd ? 8'h00 : d});
        reg_write(8'h08, {7'h0, rd, lo, 8'h00, d});
    endtask

    task automatic wait_ready(output logic [31:0] st);
        for (int i = 0; i < 50; i++) begin
            reg_read(8'h14, st);
            if (st[1]) return;
        end
        chk(1'b0, "R3 ready timeout", st, 32'h2);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, st;
        logic [14:0] ta;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        reg_read(8'h14, v);  chk(v == 32'h2, "R1 status", v, 32'h2);
        reg_read(8'h1C, v);  chk(v == 32'h0, "R1 mode", v, 0);
        chk(req_valid == 1'b0, "R1 req_valid", {31'h0, req_valid}, 0);

        // R9 mode register and read-modify-write
        reg_write(8'h1C, 32'hFFFF_F2A5);
        reg_read(8'h1C, v);  chk(v == 32'h2A5, "R9 mode readback", v, 32'h2A5);
        v = (v & 32'hF) | (32'h13 << 4);
        reg_write(8'h1C, v);
        reg_read(8'h1C, v);  chk(v == 32'h135, "R9 mode bits kept", v, 32'h135);
        cur_hi = 7'h13;

        // R2/R3 write transfer
        send_cmd(1'b0, 8'h44, 8'hC3);
        #1 chk(req_valid && req_addr == 15'h1344 && !req_read && req_wdata == 8'hC3,
               "R2 request", {req_valid, req_read, req_addr, req_wdata}, {2'b10, 15'h1344, 8'hC3});
        reg_read(8'h14, v);  chk(v[1:0] == 2'b01, "R2 busy status", v, 1);
        repeat (2) @(negedge clk);
        chk(req_valid && req_addr == 15'h1344, "R10 request held", {17'h0, req_addr}, 32'h1344);
        wait_ready(st);
        chk(st[2:0] == 3'b010, "R3 write done", st, 2);

        // R7 overrun while busy, R4 read
        send_cmd(1'b1, 8'h55, 8'h00);
        reg_write(8'h08, {7'h0, 1'b0, 8'h99, 8'h00, 8'h77});
        #1 chk(req_read && req_addr == 15'h1355, "R7 command ignored",
               {16'h0, req_read, req_addr}, {16'h0, 1'b1, 15'h1355});
        reg_read(8'h14, v);  chk(v[3] == 1'b1, "R7 overrun set", v, 32'h9);
        wait_ready(st);
        ta = 15'h1355;
        chk(st[2] == 1'b1, "R4 rd_ready", st, 32'hE);
        reg_read(8'h10, v);  chk(v == {24'h0, eng_byte(ta)}, "R4 read byte", v, {24'h0, eng_byte(ta)});
        reg_read(8'h14, v);  chk(v[2] == 1'b0, "R5 rd_ready cleared", v, 32'hA);
        reg_read(8'h10, v);  chk(v == {24'h0, eng_byte(ta)}, "R5 byte kept", v, {24'h0, eng_byte(ta)});
        chk(exp_q.size() == 0, "R7 no extra request", exp_q.size(), 0);

        // R8 overrun clear rules
        reg_write(8'h14, 32'h0);
        reg_read(8'h14, v);  chk(v[3] == 1'b1, "R8 zero keeps overrun", v, 32'hA);
        reg_write(8'h14, 32'h8);
        reg_read(8'h14, v);  chk(v[3] == 1'b0, "R8 one clears overrun", v, 32'h2);

        // R6 new command clears read-ready
        send_cmd(1'b1, 8'h0F, 8'h00);
        wait_ready(st);
        chk(st[2] == 1'b1, "R6 rd_ready before", st, 32'h6);
        send_cmd(1'b0, 8'h0F, 8'h3C);
        reg_read(8'h14, v);  chk(v[2:0] == 3'b001, "R6 rd_ready cleared", v, 1);
        wait_ready(st);

        // R11 back-to-back reads, same address, new high part
        reg_write(8'h1C, 32'h7F5);
        cur_hi = 7'h7F;
        ta = {7'h7F, 8'hA0};
        for (int k = 0; k < 4; k++) begin
            send_cmd(1'b1, 8'hA0, 8'h00);
            #1 chk(req_valid, "R11 accepted", {31'h0, req_valid}, 1);
            wait_ready(st);
            reg_read(8'h10, v);
            chk(v == {24'h0, eng_byte(ta)}, "R11 byte", v, {24'h0, eng_byte(ta)});
        end
        chk(exp_q.size() == 0, "R11 all requests seen", exp_q.size(), 0);

        reg_read(8'h00, v);  chk(v == 32'h0, "R9 unmapped offset", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule